// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Sequencer

This block is a hardware master that loads a configuration image into a target FPGA over a passive-serial link. A single start pulse launches a fixed sequence. The block pulls the target's active-low configuration request low for a timed interval and confirms that the target pulled its active-low status pin low in reply. It then releases the request, waits a settle time and polls for status release, giving up after a timeout. Next it streams the image one bit per serial clock, least-significant bit first. Last, it checks the target's config-done pin and sends a fixed number of trailing clock pulses.

Image bytes arrive on a valid/ready handshake, and the total number of bytes is given with the start pulse. All waits are parameters in microseconds, scaled by the system clock frequency in MHz. The serial clock half-period is a parameter counted in system clocks, which keeps the link below the target's maximum rate. The status and config-done inputs pass through two-flop synchronisers before the controller uses them. An abort input ends any load in progress. A one-cycle done pulse reports the outcome on a 3-bit result code.

Top module: `pscfg_top`

## Requirements
- R1: After reset: nConfig=1, dclk=0, inReady=0, busy=0, done=0 and result=0.
- R2: start in idle drives nConfig low for exactly CLK_MHZ*CFG_LOW_US cycles. If the synchronised nStatusIn is then still high, the load ends with result 1 (status not asserted) and no dclk rising edge.
- R3: After nConfig is released and CLK_MHZ*SETTLE_US cycles have passed, the block waits for nStatusIn to go high. If it stays low for CLK_MHZ*TIMEOUT_US cycles, the load ends with result 2 (release timeout) and no dclk rising edge.
- R4: Each byte accepted on the handshake is shifted out on dataOut least-significant bit first, one bit per dclk rising edge, for exactly byteCount bytes. A byteCount of 0 sends no data bits.
- R5: dclk high and low phases of data bits each last HALF_CYC cycles. dataOut never changes while dclk is high.
- R6: After the last data bit, if the synchronised confDoneIn is low, the load ends with result 3 (config-done missing) and no further dclk rising edge.
- R7: If confDoneIn is high, exactly TRAIL_PULSES further dclk pulses (high, then low) follow, and the load ends with result 0 (ok).
- R8: abortReq while a load is active ends it on the next clock with result 4 (aborted), nConfig high and dclk low.
- R9: inReady is high only while the block waits for the next byte. It is never high while dclk is high or while nConfig is low.
- R10: done is a one-cycle pulse. result takes its new value in that cycle and holds it until the next load ends. busy is high from the cycle after start until the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only while idle |
| byteCount | input | CNT_W | Number of image bytes, sampled with start |
| inData | input | 8 | Image byte |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | Block takes inData this cycle if inValid |
| abortReq | input | 1 | Abort the load in progress |
| nStatusIn | input | 1 | Target status pin, active low |
| confDoneIn | input | 1 | Target config-done pin |
| nConfig | output | 1 | Configuration request to target, active low |
| dclk | output | 1 | Serial configuration clock |
| dataOut | output | 1 | Serial configuration data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| result | output | 3 | 0 ok, 1 no status, 2 timeout, 3 no config-done, 4 aborted |

## Verification
A controller in the wrong state shows up at the pins within one serial half-period. Possible signs are a missing or extra dclk rising edge, a dclk high phase of the wrong length, data moving under a high clock, or inReady raised outside a byte wait. A wrong bit or byte counter changes the rising-edge total or the captured bytes, which are known by the end of the load. A wrong timer or a wrong use of the synchronised inputs appears as a wrong nConfig low width or a wrong result code at the done pulse.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CFG_LOW, S_SETTLE, S_WAIT_STAT, S_FETCH, S_BIT_LO, S_BIT_HI,
    S_CHECK_DONE, S_TRAIL_HI, S_TRAIL_LO, S_FINISH
  } seqState_t;

  typedef enum logic [2:0] {
    RES_OK = 3'd0, RES_NO_STATUS = 3'd1, RES_TIMEOUT = 3'd2,
    RES_NO_CONFDONE = 3'd3, RES_ABORTED = 3'd4
  } result_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTmr;
    logic loadCount;
    logic takeByte;
    logic shiftBit;
    logic clrTrail;
    logic incTrail;
  } dpCtrl_t;

  // flags from datapath to control
  typedef struct packed {
    logic cfgLowHit;
    logic settleHit;
    logic timeoutHit;
    logic halfHit;
    logic lastBit;
    logic bytesZero;
    logic lastTrail;
    logic statusHigh;
    logic confDoneHigh;
  } dpStat_t;
endpackage

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pscfg_datapath.sv
module pscfg_datapath
  import pscfg_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int CFG_LOW_CYC  = 500,
  parameter int SETTLE_CYC   = 500,
  parameter int TIMEOUT_CYC  = 25000000,
  parameter int HALF_CYC     = 4,
  parameter int TRAIL_PULSES = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       inData,
  input  logic             nStatusIn,
  input  logic             confDoneIn,
  output dpStat_t          stat,
  output logic             dataOut
);
  localparam int MAX_A  = (CFG_LOW_CYC > SETTLE_CYC) ? CFG_LOW_CYC : SETTLE_CYC;
  localparam int MAX_B  = (TIMEOUT_CYC > HALF_CYC) ? TIMEOUT_CYC : HALF_CYC;
  localparam int MAXC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W  = $clog2(MAXC + 1);
  localparam int TR_W   = $clog2(TRAIL_PULSES + 1);

  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] bytesLeft;
  logic [2:0]       bitCnt;
  logic [TR_W-1:0]  trailCnt;
  logic [7:0]       shreg;
  logic             statusSync, confDoneSync;

  pscfg_sync #(.STAGES(2), .RESET_VAL(1'b1)) uStatSync (
    .clk(clk), .rstN(rstN), .d(nStatusIn), .q(statusSync));
  pscfg_sync #(.STAGES(2), .RESET_VAL(1'b0)) uDoneSync (
    .clk(clk), .rstN(rstN), .d(confDoneIn), .q(confDoneSync));

  // interval timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         tmr <= '0;
    else if (ctl.clrTmr)               tmr <= '0;
    else if (tmr != TMR_W'(MAXC))      tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytesLeft <= '0;
      bitCnt    <= '0;
      shreg     <= '0;
      trailCnt  <= '0;
    end else begin
      if (ctl.loadCount) bytesLeft <= byteCount;
      if (ctl.takeByte) begin
        bytesLeft <= bytesLeft - 1'b1;
        shreg     <= inData;
        bitCnt    <= '0;
      end else if (ctl.shiftBit) begin
        shreg  <= {1'b0, shreg[7:1]};
        bitCnt <= bitCnt + 1'b1;
      end
      if (ctl.clrTrail)      trailCnt <= '0;
      else if (ctl.incTrail) trailCnt <= trailCnt + 1'b1;
    end
  end

  assign dataOut           = shreg[0];
  assign stat.cfgLowHit    = (tmr == TMR_W'(CFG_LOW_CYC - 1));
  assign stat.settleHit    = (tmr == TMR_W'(SETTLE_CYC - 1));
  assign stat.timeoutHit   = (tmr == TMR_W'(TIMEOUT_CYC - 1));
  assign stat.halfHit      = (tmr == TMR_W'(HALF_CYC - 1));
  assign stat.lastBit      = (bitCnt == 3'd7);
  assign stat.bytesZero    = (bytesLeft == '0);
  assign stat.lastTrail    = (trailCnt == TR_W'(TRAIL_PULSES - 1));
  assign stat.statusHigh   = statusSync;
  assign stat.confDoneHigh = confDoneSync;

  // R4: a byte is only taken when the previous one is fully shifted
  a_r4_take_after_last_bit: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeByte && $past(ctl.shiftBit) |-> $past(bitCnt) == 3'd7);
endmodule

// File: rtl/pscfg_ctrl.sv
module pscfg_ctrl
  import pscfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       inValid,
  input  logic       abortReq,
  input  dpStat_t    stat,
  output dpCtrl_t    ctl,
  output logic       inReady,
  output logic       nConfig,
  output logic       dclk,
  output logic       busy,
  output logic       done,
  output logic [2:0] result
);
  seqState_t state, nextState;
  result_t   resultQ, nextResult;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      resultQ <= RES_OK;
    end else begin
      state   <= nextState;
      resultQ <= nextResult;
    end
  end

  always_comb begin
    nextState  = state;
    nextResult = resultQ;
    ctl        = '0;
    unique case (state)
      S_IDLE: if (start) begin
        nextState     = S_CFG_LOW;
        ctl.clrTmr    = 1'b1;
        ctl.loadCount = 1'b1;
      end
      S_CFG_LOW: if (stat.cfgLowHit) begin
        ctl.clrTmr = 1'b1;
        if (!stat.statusHigh) nextState = S_SETTLE;
        else begin
          nextState  = S_FINISH;
          nextResult = RES_NO_STATUS;
        end
      end
      S_SETTLE: if (stat.settleHit) begin
        nextState  = S_WAIT_STAT;
        ctl.clrTmr = 1'b1;
      end
      S_WAIT_STAT: begin
        if (stat.statusHigh) begin
          ctl.clrTmr = 1'b1;
          nextState  = stat.bytesZero ? S_CHECK_DONE : S_FETCH;
        end else if (stat.timeoutHit) begin
          nextState  = S_FINISH;
          nextResult = RES_TIMEOUT;
        end
      end
      S_FETCH: if (inValid) begin
        ctl.takeByte = 1'b1;
        ctl.clrTmr   = 1'b1;
        nextState    = S_BIT_LO;
      end
      S_BIT_LO: if (stat.halfHit) begin
        ctl.clrTmr = 1'b1;
        nextState  = S_BIT_HI;
      end
      S_BIT_HI: if (stat.halfHit) begin
        ctl.clrTmr   = 1'b1;
        ctl.shiftBit = 1'b1;
        if (!stat.lastBit)       nextState = S_BIT_LO;
        else if (stat.bytesZero) nextState = S_CHECK_DONE;
        else                     nextState = S_FETCH;
      end
      S_CHECK_DONE: if (stat.halfHit) begin
        ctl.clrTmr = 1'b1;
        if (stat.confDoneHigh) begin
          ctl.clrTrail = 1'b1;
          nextState    = S_TRAIL_HI;
        end else begin
          nextState  = S_FINISH;
          nextResult = RES_NO_CONFDONE;
        end
      end
      S_TRAIL_HI: if (stat.halfHit) begin
        ctl.clrTmr = 1'b1;
        nextState  = S_TRAIL_LO;
      end
      S_TRAIL_LO: if (stat.halfHit) begin
        ctl.clrTmr = 1'b1;
        if (stat.lastTrail) begin
          nextState  = S_FINISH;
          nextResult = RES_OK;
        end else begin
          ctl.incTrail = 1'b1;
          nextState    = S_TRAIL_HI;
        end
      end
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
    // abort overrides any step of an active load
    if (abortReq && state != S_IDLE && state != S_FINISH) begin
      ctl        = '0;
      nextState  = S_FINISH;
      nextResult = RES_ABORTED;
    end
  end

  assign nConfig = (state != S_CFG_LOW);
  assign dclk    = (state == S_BIT_HI) || (state == S_TRAIL_HI);
  assign inReady = (state == S_FETCH);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FINISH);
  assign result  = resultQ;

  // R8: abort during a load ends it on the next clock with the aborted code
  a_r8_abort_ends: assert property (@(posedge clk) disable iff (!rstN)
    abortReq && state != S_IDLE && state != S_FINISH
    |=> state == S_FINISH && resultQ == RES_ABORTED);

  // R10: result only moves when a load finishes
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(resultQ) || $past(state) != S_FINISH);
endmodule

// File: rtl/pscfg_top.sv
module pscfg_top
  import pscfg_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int CLK_MHZ      = 250,
  parameter int CFG_LOW_US   = 2,
  parameter int SETTLE_US    = 2,
  parameter int TIMEOUT_US   = 100000,
  parameter int HALF_CYC     = 4,
  parameter int TRAIL_PULSES = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic             abortReq,
  input  logic             nStatusIn,
  input  logic             confDoneIn,
  output logic             nConfig,
  output logic             dclk,
  output logic             dataOut,
  output logic             busy,
  output logic             done,
  output logic [2:0]       result
);
  localparam int CFG_LOW_CYC = CLK_MHZ * CFG_LOW_US;
  localparam int SETTLE_CYC  = CLK_MHZ * SETTLE_US;
  localparam int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;

  dpCtrl_t ctl;
  dpStat_t stat;

  pscfg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .abortReq(abortReq), .stat(stat), .ctl(ctl), .inReady(inReady),
    .nConfig(nConfig), .dclk(dclk), .busy(busy), .done(done), .result(result));

  pscfg_datapath #(
    .CNT_W(CNT_W), .CFG_LOW_CYC(CFG_LOW_CYC), .SETTLE_CYC(SETTLE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .HALF_CYC(HALF_CYC), .TRAIL_PULSES(TRAIL_PULSES)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteCount(byteCount), .inData(inData),
    .nStatusIn(nStatusIn), .confDoneIn(confDoneIn), .stat(stat), .dataOut(dataOut));

  // R5: data held steady through a high serial clock
  a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    dclk && $past(dclk) |-> $stable(dataOut));

  // R9: byte request never overlaps a high clock or a held config request
  a_r9_ready_window: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !dclk && nConfig);

  // R10: done is a single-cycle pulse with a legal code
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_result_legal: assert property (@(posedge clk) disable iff (!rstN)
    done |-> result <= 3'd4);

  // R8: pins return to rest when not loading
  a_r8_idle_pins: assert property (@(posedge clk) disable iff (!rstN)
    !busy || done |-> nConfig && !dclk);
endmodule

// File: tb/tb_pscfg_top.sv
module tb_pscfg_top;
  localparam int CNT_W = 16;
  localparam int MHZ = 10, LOW_US = 2, SET_US = 2, TO_US = 100;
  localparam int HALF = 3, TRAIL = 12;
  localparam int LOW_CYC = MHZ * LOW_US;
  localparam int TO_CYC  = MHZ * TO_US;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, abortReq = 1'b0;
  logic [CNT_W-1:0] byteCount = '0;
  logic [7:0] inData;
  logic inValid = 1'b1;
  logic inReady, nStatusIn, confDoneIn, nConfig, dclk, dataOut, busy, done;
  logic [2:0] result;

  pscfg_top #(.CNT_W(CNT_W), .CLK_MHZ(MHZ), .CFG_LOW_US(LOW_US), .SETTLE_US(SET_US),
    .TIMEOUT_US(TO_US), .HALF_CYC(HALF), .TRAIL_PULSES(TRAIL)) dut (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount), .inData(inData),
    .inValid(inValid), .inReady(inReady), .abortReq(abortReq), .nStatusIn(nStatusIn),
    .confDoneIn(confDoneIn), .nConfig(nConfig), .dclk(dclk), .dataOut(dataOut),
    .busy(busy), .done(done), .result(result));

  always #2 clk = ~clk;

  int nChecks = 0, nFails = 0;
  // target model
  int stMode = 0;      // 0 follows nConfig, 1 never low, 2 stuck low
  logic cdEnable = 1'b1;
  int expBits = 0;
  int edges = 0;
  assign nStatusIn  = (stMode == 0) ? nConfig : (stMode == 1);
  assign confDoneIn = cdEnable && (edges >= expBits);

  // image source
  logic [7:0] img [0:7];
  int feedIdx = 0;
  logic feedRst = 1'b0;
  assign inData = img[feedIdx];
  always @(posedge clk) begin
    if (feedRst) feedIdx <= 0;
    else if (inValid && inReady) feedIdx <= feedIdx + 1;
  end

  // pin monitor, sampled away from the active edge
  logic [7:0] cap [0:31];
  logic prevDclk = 1'b0, prevData = 1'b0;
  int highRun = 0, highBad = 0, dataBad = 0, lowCnt = 0, readyBad = 0;
  always @(negedge clk) begin
    if (dclk && !prevDclk) begin
      if (edges < 256) cap[edges / 8][edges % 8] = dataOut;
      edges = edges + 1;
    end
    if (dclk && prevDclk && dataOut != prevData) dataBad = dataBad + 1;
    if (dclk) highRun = highRun + 1;
    else begin
      if (prevDclk && highRun != HALF) highBad = highBad + 1;
      highRun = 0;
    end
    if (!nConfig) lowCnt = lowCnt + 1;
    if (inReady && (dclk || !nConfig)) readyBad = readyBad + 1;
    prevDclk = dclk;
    prevData = dataOut;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    edges = 0; highBad = 0; dataBad = 0; lowCnt = 0; readyBad = 0;
    feedRst = 1'b1;
    @(negedge clk);
    feedRst = 1'b0;
  endtask

  int loadCycles;
  task automatic runLoad(input int n);
    byteCount = CNT_W'(n);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    loadCycles = 1;
    while (!done && loadCycles < 60000) begin
      @(negedge clk);
      loadCycles++;
    end
  endtask

  task automatic testReset();
    check(nConfig == 1'b1, "R1 nConfig", nConfig, 1);
    check(dclk == 1'b0, "R1 dclk", dclk, 0);
    check(inReady == 1'b0, "R1 inReady", inReady, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(result == 3'd0, "R1 result", result, 0);
  endtask

  task automatic testGood(input int n, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2);
    img[0] = b0; img[1] = b1; img[2] = b2;
    stMode = 0; cdEnable = 1'b1; expBits = 8 * n;
    clearMon();
    runLoad(n);
    check(done && result == 3'd0, "R7 ok result", result, 0);
    check(edges == 8 * n + TRAIL, "R7 rising edge total", edges, 8 * n + TRAIL);
    for (int i = 0; i < n; i++)
      check(cap[i] == img[i], "R4 byte lsb first", cap[i], img[i]);
    check(lowCnt == LOW_CYC, "R2 nConfig low width", lowCnt, LOW_CYC);
    check(dataBad == 0, "R5 data moved under high dclk", dataBad, 0);
    check(highBad == 0, "R5 high phase width", highBad, 0);
    check(readyBad == 0, "R9 ready window", readyBad, 0);
    @(negedge clk);
    check(!done, "R10 done single cycle", done, 0);
    check(!busy, "R10 busy low after done", busy, 0);
    repeat (5) @(negedge clk);
    check(result == 3'd0, "R10 result held", result, 0);
  endtask

  task automatic testNoStatus();
    stMode = 1; cdEnable = 1'b1; expBits = 0;
    clearMon();
    runLoad(2);
    check(done && result == 3'd1, "R2 status not asserted", result, 1);
    check(edges == 0, "R2 no clocks", edges, 0);
    check(lowCnt == LOW_CYC, "R2 low width on failure", lowCnt, LOW_CYC);
    @(negedge clk);
  endtask

  task automatic testTimeout();
    stMode = 2; cdEnable = 1'b1; expBits = 0;
    clearMon();
    runLoad(2);
    check(done && result == 3'd2, "R3 release timeout", result, 2);
    check(loadCycles >= TO_CYC && loadCycles < TO_CYC + 100, "R3 timeout length",
          loadCycles, TO_CYC);
    check(edges == 0, "R3 no clocks", edges, 0);
    @(negedge clk);
    stMode = 0;
  endtask

  task automatic testNoConfDone();
    img[0] = 8'h5A; img[1] = 8'hC3;
    stMode = 0; cdEnable = 1'b0; expBits = 16;
    clearMon();
    runLoad(2);
    check(done && result == 3'd3, "R6 config-done missing", result, 3);
    check(edges == 16, "R6 no trailing clocks", edges, 16);
    check(cap[1] == 8'hC3, "R4 second byte", cap[1], 8'hC3);
    @(negedge clk);
    cdEnable = 1'b1;
  endtask

  task automatic testAbort();
    int guard = 0;
    img[0] = 8'hFF; img[1] = 8'h00; img[2] = 8'h55; img[3] = 8'hAA;
    stMode = 0; cdEnable = 1'b1; expBits = 32;
    clearMon();
    byteCount = CNT_W'(4);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (edges < 5 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    check(done && result == 3'd4, "R8 aborted result", result, 4);
    check(nConfig == 1'b1 && dclk == 1'b0, "R8 pins at rest", {nConfig, dclk}, 2);
    check(edges < 32, "R8 stream cut short", edges, 5);
    @(negedge clk);
    check(!busy && !inReady, "R8 idle after abort", {busy, inReady}, 0);
  endtask

  task automatic testZero();
    stMode = 0; cdEnable = 1'b1; expBits = 0;
    clearMon();
    runLoad(0);
    check(done && result == 3'd0, "R4 zero count ok", result, 0);
    check(edges == TRAIL, "R7 trailing only", edges, TRAIL);
    check(readyBad == 0, "R9 no ready on zero count", readyBad, 0);
    @(negedge clk);
  endtask

  // watchdog
  int wdog = 0;
  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", wdog, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) img[i] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testGood(2, 8'hA5, 8'h3C, 8'h00);
    testGood(3, 8'h01, 8'h80, 8'hFF);
    testNoStatus();
    testTimeout();
    testNoConfDone();
    testAbort();
    testZero();
    testGood(1, 8'h96, 8'h00, 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule